// File: doc/BRIEF.md
# Receive Frame Descriptor Checker

This block sits between a network controller's receive buffer and a byte-wide stream consumer. When `poll` is pulsed it fetches 16-bit words from the buffer data port and reads the 4-byte descriptor that comes before every received frame. The descriptor holds a ready marker, a status byte and a little-endian 16-bit length. From these bytes the block decides one of four outcomes: no frame is waiting, the controller is in a bad state and needs reinitialising, the frame must be thrown away, or the frame is good. A good frame is sent out as bytes on a valid/ready stream, with `tlast` on the final byte.

The word port uses a simple request/response scheme. `fetch_req` asks for one word. `fetch_peek` marks a read that leaves the buffer pointer where it is. Every other read moves the pointer on by one word. The first peek of the marker can come back as 00h even when a frame is waiting, so a peek that does not show 01h is made a second time before the block decides. A rejected frame is still read through to its end, so the next poll starts on a descriptor boundary. The status byte and the length are held on sideband outputs from the first payload byte until the next poll.

Top module: `rx_desc_check`

## Requirements
- R1: While reset is low, and on the first cycle after it, `m_tvalid`, `fetch_req`, `busy`, `no_frame`, `reinit_req` and `frm_drop` are all 0.
- R2: If the first marker peek returns 01h in its low byte, there is no second peek. The block then makes two advancing reads for the descriptor: word 0 holds the marker in bits 7:0 and the status in bits 15:8, and word 1 holds the length.
- R3: If the first peek returns anything other than 01h, exactly one more peek is made. A 01h from that second peek starts the frame exactly as in R2.
- R4: If both peeks return 00h, `no_frame` pulses for one cycle and the block makes no advancing read.
- R5: If the second peek returns a value other than 01h or 00h, `reinit_req` pulses for one cycle and the block makes no advancing read.
- R6: Marker reads are the only reads made with `fetch_peek` high. Every descriptor read and every payload read is an advancing read.
- R7: A frame is rejected when its status byte ANDed with BFh is non-zero. Bit 6 on its own does not cause a rejection.
- R8: A frame is rejected when its length is 1522 or more, or less than 64. A length of 1521 is accepted.
- R9: For a rejected frame, `frm_drop` pulses once and the block makes exactly ceil(length/2) further advancing reads. It emits no bytes, and the next poll finds the following descriptor.
- R10: For an accepted frame, exactly `length` bytes come out. Each payload word gives bits 7:0 first and then bits 15:8.
- R11: When the length is odd, the upper byte of the last word is dropped. `m_tlast` is high on the last byte emitted and on no other byte.
- R12: On the first payload byte, `frm_status` and `frm_len` hold the frame's status byte and length.
- R13: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll | input | 1 | Starts one descriptor check; ignored while busy |
| fetch_req | output | 1 | One-cycle request for one buffer word |
| fetch_peek | output | 1 | With `fetch_req`: read without advancing the pointer |
| fetch_valid | input | 1 | Response strobe for the outstanding request |
| fetch_data | input | 16 | Response word |
| m_tvalid | output | 1 | Payload byte valid |
| m_tready | input | 1 | Consumer accepts the byte |
| m_tdata | output | 8 | Payload byte |
| m_tlast | output | 1 | Last byte of the frame |
| frm_status | output | 8 | Status byte of the current frame |
| frm_len | output | 16 | Length of the current frame |
| no_frame | output | 1 | Pulse: no frame waiting |
| reinit_req | output | 1 | Pulse: unexpected marker, controller needs reinitialising |
| frm_drop | output | 1 | Pulse: frame rejected and being drained |
| busy | output | 1 | A check or a transfer is in progress |

## Verification
The assertions assume that the word source raises `fetch_valid` only for a request that is still outstanding, answers after at least one cycle, and never answers one request twice. They also assume `m_tready` may stall for any number of cycles. The bench's buffer model meets all of this: it answers every request exactly one cycle later and counts peeks and advancing reads separately, so each read pattern can be checked at the ports. Backpressure in the bench comes from a pseudo-random pattern on `m_tready`, and the forced 00h first peek comes from a one-shot override in the model.

// File: rtl/rxd_pkg.sv
// Shared constants and the sequencer state type for the receive
// descriptor checker.
package rxd_pkg;
    localparam logic [7:0] MARK_READY  = 8'h01;
    localparam logic [7:0] MARK_EMPTY  = 8'h00;
    localparam logic [7:0] STAT_REJECT = 8'hBF;
    localparam int         WORD_W      = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_PK1, S_PK2, S_HD0, S_HD1, S_PAY, S_DRN, S_FIN
    } seq_state_t;
endpackage

// File: rtl/rxd_seq.sv
// Descriptor sequencer. It peeks the ready marker (two tries at most),
// reads the status/length words, judges the frame, and then fetches the
// payload words or drains them. Assumes at most one outstanding fetch,
// with the response strobed by fetch_valid at least one cycle later.
module rxd_seq
    import rxd_pkg::*;
#(
    parameter int MAX_LEN = 1522,
    parameter int MIN_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll,
    output logic              fetch_req,
    output logic              fetch_peek,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_data,
    input  logic              unp_empty,
    output logic              word_load,
    output logic [WORD_W-1:0] word_data,
    output logic              word_two,
    output logic              word_last,
    output logic [7:0]        frm_status,
    output logic [WORD_W-1:0] frm_len,
    output logic              no_frame,
    output logic              reinit_req,
    output logic              frm_drop,
    output logic              busy
);
    localparam logic [WORD_W-1:0] LEN_HI = WORD_W'(MAX_LEN);
    localparam logic [WORD_W-1:0] LEN_LO = WORD_W'(MIN_LEN);

    seq_state_t        st;
    logic              pend;
    logic [WORD_W-1:0] words_left;
    logic [7:0]        mark;
    logic [WORD_W-1:0] word_cnt;
    logic              stat_bad, len_bad, want_word;

    // Decode of the returned word and the frame checks.
    assign mark     = fetch_data[7:0];
    assign word_cnt = {1'b0, fetch_data[WORD_W-1:1]} + WORD_W'(fetch_data[0]);
    assign stat_bad = |(frm_status & STAT_REJECT);
    assign len_bad  = (fetch_data >= LEN_HI) || (fetch_data < LEN_LO);

    // Request generation: one word at a time, payload only into an empty unpacker.
    always_comb begin
        unique case (st)
            S_PK1, S_PK2, S_HD0, S_HD1, S_DRN: want_word = 1'b1;
            S_PAY:                             want_word = unp_empty;
            default:                           want_word = 1'b0;
        endcase
    end
    assign fetch_req  = want_word && !pend;
    assign fetch_peek = (st == S_PK1) || (st == S_PK2);

    // Word hand-off to the unpacker.
    assign word_load = (st == S_PAY) && fetch_valid;
    assign word_data = fetch_data;
    assign word_last = (words_left == WORD_W'(1));
    assign word_two  = !(word_last && frm_len[0]);
    assign busy      = (st != S_IDLE);

    // Sequencer state, outstanding flag, counters and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            pend       <= 1'b0;
            words_left <= '0;
            frm_status <= '0;
            frm_len    <= '0;
            no_frame   <= 1'b0;
            reinit_req <= 1'b0;
            frm_drop   <= 1'b0;
        end else begin
            no_frame   <= 1'b0;
            reinit_req <= 1'b0;
            frm_drop   <= 1'b0;
            if (fetch_req)        pend <= 1'b1;
            else if (fetch_valid) pend <= 1'b0;
            case (st)
                S_IDLE: if (poll) st <= S_PK1;
                S_PK1:  if (fetch_valid) st <= (mark == MARK_READY) ? S_HD0 : S_PK2;
                S_PK2: begin
                    if (fetch_valid) begin
                        if (mark == MARK_READY) begin
                            st <= S_HD0;
                        end else begin
                            st <= S_IDLE;
                            if (mark == MARK_EMPTY) no_frame <= 1'b1;
                            else                    reinit_req <= 1'b1;
                        end
                    end
                end
                S_HD0: begin
                    if (fetch_valid) begin
                        frm_status <= fetch_data[15:8];
                        st         <= S_HD1;
                    end
                end
                S_HD1: begin
                    if (fetch_valid) begin
                        frm_len    <= fetch_data;
                        words_left <= word_cnt;
                        if (stat_bad || len_bad) begin
                            frm_drop <= 1'b1;
                            st       <= (word_cnt == '0) ? S_IDLE : S_DRN;
                        end else begin
                            st <= S_PAY;
                        end
                    end
                end
                S_PAY, S_DRN: begin
                    if (fetch_valid) begin
                        words_left <= words_left - WORD_W'(1);
                        if (words_left == WORD_W'(1))
                            st <= (st == S_PAY) ? S_FIN : S_IDLE;
                    end
                end
                S_FIN:   if (unp_empty) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // At most one outcome pulse in any cycle (R4, R5, R9).
    p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({no_frame, reinit_req, frm_drop}) <= 1);
    // A reinitialise request follows a peek response (R5).
    p_reinit_after_peek_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && st == S_PK2 && mark != MARK_READY && mark != MARK_EMPTY)
        |=> reinit_req);
endmodule

// File: rtl/rxd_unpack.sv
// Word-to-byte unpacker. It holds one 16-bit word and emits bits 7:0
// first and bits 15:8 second, or only the low byte when word_two is low.
// Assumes a new word is loaded only while it is empty.
module rxd_unpack
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_load,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_two,
    input  logic              word_last,
    input  logic              m_tready,
    output logic              m_tvalid,
    output logic [7:0]        m_tdata,
    output logic              m_tlast,
    output logic              unp_empty
);
    logic [WORD_W-1:0] hold;
    logic [1:0]        left;
    logic              hi_sel, last_w;

    // Byte select and stream flags from the held word.
    assign m_tvalid  = (left != 2'd0);
    assign m_tdata   = hi_sel ? hold[15:8] : hold[7:0];
    assign m_tlast   = last_w && (left == 2'd1);
    assign unp_empty = (left == 2'd0);

    // Load a word, or step to the next byte on a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            left   <= 2'd0;
            hi_sel <= 1'b0;
            last_w <= 1'b0;
        end else if (word_load) begin
            hold   <= word_data;
            left   <= word_two ? 2'd2 : 2'd1;
            hi_sel <= 1'b0;
            last_w <= word_last;
        end else if (m_tvalid && m_tready) begin
            left   <= left - 2'd1;
            hi_sel <= 1'b1;
        end
    end

    // A stalled byte holds steady (R13).
    p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
    // The sequencer only loads into an empty unpacker (R11).
    p_load_when_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |-> unp_empty);
endmodule

// File: rtl/rx_desc_check.sv
// Top of the receive descriptor checker: the sequencer that judges the
// descriptor plus the unpacker that streams the bytes out. Assumes the
// buffer port answers each request exactly once with fetch_valid.
module rx_desc_check
    import rxd_pkg::*;
#(
    parameter int MAX_LEN = 1522,
    parameter int MIN_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        poll,
    output logic        fetch_req,
    output logic        fetch_peek,
    input  logic        fetch_valid,
    input  logic [15:0] fetch_data,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic [7:0]  m_tdata,
    output logic        m_tlast,
    output logic [7:0]  frm_status,
    output logic [15:0] frm_len,
    output logic        no_frame,
    output logic        reinit_req,
    output logic        frm_drop,
    output logic        busy
);
    logic              unp_empty, word_load, word_two, word_last;
    logic [WORD_W-1:0] word_data;

    rxd_seq #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .poll(poll),
        .fetch_req(fetch_req), .fetch_peek(fetch_peek),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .unp_empty(unp_empty), .word_load(word_load), .word_data(word_data),
        .word_two(word_two), .word_last(word_last),
        .frm_status(frm_status), .frm_len(frm_len),
        .no_frame(no_frame), .reinit_req(reinit_req), .frm_drop(frm_drop),
        .busy(busy)
    );

    rxd_unpack u_unp (
        .clk(clk), .rst_n(rst_n), .word_load(word_load), .word_data(word_data),
        .word_two(word_two), .word_last(word_last), .m_tready(m_tready),
        .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .unp_empty(unp_empty)
    );

    // Bytes only flow while a frame is in progress (R10).
    p_stream_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> busy);
    // Nothing follows the last byte within the same poll (R11).
    p_last_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);
endmodule

// File: tb/rx_desc_check_test.sv
module rx_desc_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll = 1'b0;
    logic        fetch_req, fetch_peek;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_data = '0;
    logic        m_tvalid, m_tlast;
    logic        m_tready = 1'b1;
    logic [7:0]  m_tdata, frm_status;
    logic [15:0] frm_len;
    logic        no_frame, reinit_req, frm_drop, busy;

    always #5 clk = ~clk;

    rx_desc_check uut (.*);

    int nchk = 0, nerr = 0;
    logic [15:0] mem [0:4095];
    int rptr = 0, wptr = 0;
    int n_peek = 0, n_adv = 0;
    int glitch_req = 0, glitch_done = 0;
    logic [7:0] cap [0:4095];
    int ncap = 0, last_idx = -1, n_last = 0;
    int n_nof = 0, n_rei = 0, n_drp = 0;
    logic in_frame = 1'b0;
    logic [7:0]  sb_stat = '0;
    logic [15:0] sb_len = '0;
    logic bp_mode = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    // Buffer model: answers each request one cycle later.
    always @(posedge clk) begin
        fetch_valid <= 1'b0;
        if (rst_n && fetch_req) begin
            fetch_valid <= 1'b1;
            if (fetch_peek) begin
                n_peek = n_peek + 1;
                if (glitch_req > glitch_done) begin
                    glitch_done = glitch_done + 1;
                    fetch_data <= 16'h0000;
                end else begin
                    fetch_data <= mem[rptr[11:0]];
                end
            end else begin
                n_adv = n_adv + 1;
                fetch_data <= mem[rptr[11:0]];
                rptr = rptr + 1;
            end
        end
    end

    // Output monitor.
    always @(posedge clk) begin
        if (rst_n) begin
            if (no_frame)   n_nof = n_nof + 1;
            if (reinit_req) n_rei = n_rei + 1;
            if (frm_drop)   n_drp = n_drp + 1;
            if (m_tvalid && m_tready) begin
                if (!in_frame) begin
                    sb_stat = frm_status;
                    sb_len  = frm_len;
                end
                in_frame = !m_tlast;
                cap[ncap[11:0]] = m_tdata;
                if (m_tlast) begin
                    last_idx = ncap;
                    n_last = n_last + 1;
                end
                ncap = ncap + 1;
            end
        end
    end

    // Ready pattern for backpressure scenarios.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        m_tready = bp_mode ? lfsr[0] : 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic put_frame(input logic [7:0] st, input int len, input logic [7:0] seed);
        mem[wptr[11:0]] = {st, 8'h01}; wptr++;
        mem[wptr[11:0]] = 16'(len);    wptr++;
        for (int i = 0; i < (len + 1) / 2; i++) begin
            mem[wptr[11:0]] = {seed + 8'(2 * i + 1), seed + 8'(2 * i)};
            wptr++;
        end
    endtask

    task automatic do_poll();
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Polls once and checks a good frame; tag names the requirement at issue.
    task automatic expect_good(input string tag, input logic [7:0] st, input int len,
                               input logic [7:0] seed, input int peeks);
        int c0 = ncap, p0 = n_peek, a0 = n_adv, bad = 0;
        do_poll();
        chk({tag, " R10 byte count"}, ncap - c0, len);
        for (int i = 0; i < len; i++)
            if (cap[(c0 + i) % 4096] !== seed + 8'(i)) bad++;
        chk({tag, " R10 byte order mismatches"}, bad, 0);
        chk({tag, " R11 tlast position"}, last_idx, c0 + len - 1);
        chk({tag, " R12 sideband status"}, sb_stat, st);
        chk({tag, " R12 sideband length"}, sb_len, len);
        chk({tag, " R6 advancing reads"}, n_adv - a0, 2 + (len + 1) / 2);
        chk({tag, " peek count"}, n_peek - p0, peeks);
    endtask

    task automatic expect_drop(input string tag, input int len);
        int c0 = ncap, a0 = n_adv, d0 = n_drp;
        do_poll();
        chk({tag, " R9 drop pulse"}, n_drp - d0, 1);
        chk({tag, " R9 no bytes"}, ncap - c0, 0);
        chk({tag, " R9 drained words"}, n_adv - a0, 2 + (len + 1) / 2);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 tvalid", m_tvalid, 0);
        chk("R1 fetch_req", fetch_req, 0);
        chk("R1 busy", busy, 0);
        chk("R1 pulses", {no_frame, reinit_req, frm_drop}, 0);
        @(negedge clk) rst_n = 1'b1;
        chk("R1 idle after reset", {m_tvalid, fetch_req, busy}, 0);
    endtask

    task automatic t_direct();
        put_frame(8'h00, 64, 8'h10);
        expect_good("R2 direct", 8'h00, 64, 8'h10, 1);
    endtask

    task automatic t_retry_odd();
        glitch_req++;
        put_frame(8'h00, 65, 8'h80);
        expect_good("R3 retry odd", 8'h00, 65, 8'h80, 2);
    endtask

    task automatic t_empty();
        int p0 = n_peek, a0 = n_adv, f0 = n_nof;
        mem[wptr[11:0]] = 16'h0000;
        do_poll();
        chk("R4 no_frame pulse", n_nof - f0, 1);
        chk("R4 two peeks", n_peek - p0, 2);
        chk("R4 no advance", n_adv - a0, 0);
    endtask

    task automatic t_bad_marker();
        int p0 = n_peek, a0 = n_adv, r0 = n_rei, c0 = ncap;
        mem[wptr[11:0]] = 16'h0055;
        do_poll();
        chk("R5 reinit pulse", n_rei - r0, 1);
        chk("R5 two peeks", n_peek - p0, 2);
        chk("R5 no advance", n_adv - a0, 0);
        chk("R5 no bytes", ncap - c0, 0);
    endtask

    task automatic t_status();
        put_frame(8'h01, 70, 8'h20);
        put_frame(8'h80, 64, 8'h30);
        put_frame(8'h40, 64, 8'h40);
        expect_drop("R7 status bit0", 70);
        expect_drop("R7 status bit7", 64);
        expect_good("R7 bit6 allowed", 8'h40, 64, 8'h40, 1);
    endtask

    task automatic t_length();
        put_frame(8'h00, 63, 8'h50);
        put_frame(8'h00, 1522, 8'h60);
        put_frame(8'h00, 1521, 8'h70);
        expect_drop("R8 length 63", 63);
        expect_drop("R8 length 1522", 1522);
        expect_good("R8 length 1521", 8'h00, 1521, 8'h70, 1);
    endtask

    task automatic t_backpressure();
        int t0 = n_last;
        bp_mode = 1'b1;
        put_frame(8'h00, 66, 8'hC0);
        expect_good("R13 backpressure", 8'h00, 66, 8'hC0, 1);
        chk("R11 one tlast", n_last - t0, 1);
        bp_mode = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                nerr++;
                nchk++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("Result: errors=%0d of %0d checks", nerr, nchk);
                $finish;
            end
        join_none
        repeat (2) @(posedge clk);
        t_reset();
        repeat (2) @(negedge clk);
        t_direct();
        t_retry_odd();
        t_empty();
        t_bad_marker();
        t_status();
        t_length();
        t_backpressure();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule